// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace frames into an on-chip ring memory. While capture is armed, every frame marked valid is written at the write pointer, and the pointer then advances modulo the ring depth. When the pointer wraps, a sticky flag records that the ring now holds a full depth of history. In that case the oldest surviving frame sits at the write pointer.

A trigger pulse marks the event of interest. Software loads a post-trigger frame count before arming. After the trigger, each frame stored in a later cycle reduces that count by one. When the count reaches zero, storage stops and the block reports that acquisition is complete, leaving a chosen amount of history before and after the event. Software then reads the buffer through a small register port with a 7-bit address. It sets the read pointer, then reads the data register repeatedly: each read returns one frame and advances the pointer. The ring depth must be a power of two.

Top module: `trace_ring_capture`

## Requirements
- R1: The identification register (address 0) returns the parameter ID_VALUE. The depth register (address 1) returns DEPTH. The width register (address 2) returns FRAME_W. Writes to these three addresses have no effect.
- R2: A frame is written to the ring at the write pointer only while capture is enabled and acquisition is not complete. The write pointer (address 6) then advances by one modulo DEPTH. A valid frame at any other time changes nothing.
- R3: Storing a frame at entry DEPTH-1 sets Full (status bit 0). Full stays set until the write pointer is written or capture is re-armed.
- R4: A trigger pulse sets Triggered (status bit 1) only while capturing. A trigger arriving while Triggered is already set, or while capture is not running, is ignored.
- R5: The trigger counter (address 7) is decremented by each frame stored in a cycle after the accepted trigger. The frame that takes it to zero is the last one stored, and Complete (status bit 2) is then set. A count of zero at the trigger completes acquisition at once; the frame in the trigger cycle is still stored.
- R6: Reading the data register (address 4) returns the frame at the read pointer (address 5) and advances the read pointer by one modulo DEPTH.
- R7: Writes to either pointer keep only the low log2(DEPTH) bits. Writing the write pointer clears Full.
- R8: In the control register (address 8), bit 0 enables capture and bit 1 selects demultiplexed port mode; both read back. Writing 0 stops capture. Any control write with bit 0 set clears Triggered, Complete and Full.
- R9: Status bit 3 (idle) reads 1 whenever the block is not actively capturing, that is, when it is disabled or acquisition is complete. Status bits above bit 3 read 0.
- R10: Addresses 9 to 127 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | Frame strobe |
| frameData | input | FRAME_W | Trace frame |
| trigIn | input | 1 | Trigger pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (advances read pointer at address 4) |
| regAddr | input | 7 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from address |

## Verification
The checker watches several properties on every cycle. The write pointer holds still once acquisition is complete, and it steps by one on each accepted frame. Full is sticky and is set by a wrap. The trigger counter never rises unless software writes it. Complete never appears without Triggered. Each data read advances the read pointer by exactly one.

Some behaviours can only be shown by the bench's scenarios. These include the exact number of frames kept for each post-trigger count, which the bench sweeps from 0 to 20 so that runs both with and without wrap are covered. They also include the ordering of frames read back from the oldest entry, the filtering of a second trigger, and the masking of pointer writes.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_IDENT  = 7'd0;
  localparam logic [ADDR_W-1:0] A_DEPTH  = 7'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 7'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 7'd3;
  localparam logic [ADDR_W-1:0] A_DATA   = 7'd4;
  localparam logic [ADDR_W-1:0] A_RDPTR  = 7'd5;
  localparam logic [ADDR_W-1:0] A_WRPTR  = 7'd6;
  localparam logic [ADDR_W-1:0] A_TCOUNT = 7'd7;
  localparam logic [ADDR_W-1:0] A_CTRL   = 7'd8;

  // status bit positions (software decodes these)
  localparam int S_FULL = 0;
  localparam int S_TRIG = 1;
  localparam int S_DONE = 2;
  localparam int S_IDLE = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic ramWrite;
    logic wrPtrLoad;
    logic rdPtrLoad;
    logic rdPtrStep;
    logic fullClear;
  } trcStrobe_t;
endpackage

// File: rtl/trc_ring_ptr.sv
module trc_ring_ptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [PTR_W-1:0] loadVal,
  output logic [PTR_W-1:0] ptr
);
  // power-of-two depth: natural rollover gives the modulo
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ptr <= '0;
    else if (load) ptr <= loadVal;
    else if (step) ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 32,
  parameter int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  trcStrobe_t         strobe,
  input  logic [FRAME_W-1:0] frameData,
  input  logic [PTR_W-1:0]   loadVal,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic               full,
  output logic [FRAME_W-1:0] rdFrame
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [FRAME_W-1:0] ringMem [DEPTH];

  trc_ring_ptr #(.PTR_W(PTR_W)) u_wrPtr (
    .clk(clk), .rstN(rstN),
    .load(strobe.wrPtrLoad), .step(strobe.ramWrite),
    .loadVal(loadVal), .ptr(wrPtr)
  );

  trc_ring_ptr #(.PTR_W(PTR_W)) u_rdPtr (
    .clk(clk), .rstN(rstN),
    .load(strobe.rdPtrLoad), .step(strobe.rdPtrStep),
    .loadVal(loadVal), .ptr(rdPtr)
  );

  always_ff @(posedge clk) begin
    if (strobe.ramWrite) ringMem[wrPtr] <= frameData;
  end

  assign rdFrame = ringMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         full <= 1'b0;
    else if (strobe.fullClear)                         full <= 1'b0;
    else if (strobe.ramWrite && (wrPtr == LAST_SLOT))  full <= 1'b1;
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic              trigIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              full,
  output trcStrobe_t        strobe,
  output logic [PTR_W-1:0]  loadVal,
  output logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  ctrlWord,
  output logic [REG_W-1:0]  trigCount
);
  logic capEn, demuxSel, triggered, acqDone;
  logic capturing, trigAccept, postTrigStore, countHitsEnd;
  logic wrCtrl, wrCount, armWrite;

  assign capturing     = capEn && !acqDone;
  assign wrCtrl        = regWrEn && (regAddr == A_CTRL);
  assign wrCount       = regWrEn && (regAddr == A_TCOUNT);
  assign armWrite      = wrCtrl && regWrData[0];
  assign trigAccept    = trigIn && capturing && !triggered;
  assign postTrigStore = triggered && capturing && frameValid;
  assign countHitsEnd  = (trigCount <= REG_W'(1));

  always_comb begin
    strobe.ramWrite  = capturing && frameValid;
    strobe.wrPtrLoad = regWrEn && (regAddr == A_WRPTR);
    strobe.rdPtrLoad = regWrEn && (regAddr == A_RDPTR);
    strobe.rdPtrStep = regRdEn && (regAddr == A_DATA);
    strobe.fullClear = strobe.wrPtrLoad || armWrite;
  end

  assign loadVal = regWrData[PTR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEn    <= 1'b0;
      demuxSel <= 1'b0;
    end else if (wrCtrl) begin
      capEn    <= regWrData[0];
      demuxSel <= regWrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triggered <= 1'b0;
      acqDone   <= 1'b0;
    end else if (armWrite) begin
      triggered <= 1'b0;
      acqDone   <= 1'b0;
    end else begin
      if (trigAccept) begin
        triggered <= 1'b1;
        if (trigCount == '0) acqDone <= 1'b1;
      end else if (postTrigStore && countHitsEnd) begin
        acqDone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   trigCount <= '0;
    else if (wrCount)                            trigCount <= regWrData;
    else if (postTrigStore && trigCount != '0)   trigCount <= trigCount - REG_W'(1);
  end

  always_comb begin
    statusWord         = '0;
    statusWord[S_FULL] = full;
    statusWord[S_TRIG] = triggered;
    statusWord[S_DONE] = acqDone;
    statusWord[S_IDLE] = !capturing;
    ctrlWord           = '0;
    ctrlWord[0]        = capEn;
    ctrlWord[1]        = demuxSel;
  end
endmodule

// File: rtl/trc_regmux.sv
module trc_regmux
  import trc_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          FRAME_W  = 32,
  parameter int          PTR_W    = 4,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0011
) (
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   statusWord,
  input  logic [REG_W-1:0]   ctrlWord,
  input  logic [REG_W-1:0]   trigCount,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [FRAME_W-1:0] rdFrame,
  output logic [REG_W-1:0]   regRdData
);
  always_comb begin
    unique case (regAddr)
      A_IDENT:  regRdData = ID_VALUE;
      A_DEPTH:  regRdData = REG_W'(DEPTH);
      A_WIDTH:  regRdData = REG_W'(FRAME_W);
      A_STATUS: regRdData = statusWord;
      A_DATA:   regRdData = REG_W'(rdFrame);
      A_RDPTR:  regRdData = REG_W'(rdPtr);
      A_WRPTR:  regRdData = REG_W'(wrPtr);
      A_TCOUNT: regRdData = trigCount;
      A_CTRL:   regRdData = ctrlWord;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trc_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          FRAME_W  = 32,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               trigIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [6:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData
);
  localparam int PTR_W = $clog2(DEPTH);

  trcStrobe_t         strobe;
  logic [PTR_W-1:0]   loadVal, wrPtr, rdPtr;
  logic               full;
  logic [FRAME_W-1:0] rdFrame;
  logic [REG_W-1:0]   statusWord, ctrlWord, trigCount;

  trc_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .trigIn(trigIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .full(full), .strobe(strobe), .loadVal(loadVal),
    .statusWord(statusWord), .ctrlWord(ctrlWord), .trigCount(trigCount)
  );

  trc_datapath #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameData(frameData),
    .loadVal(loadVal), .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full),
    .rdFrame(rdFrame)
  );

  trc_regmux #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .PTR_W(PTR_W),
               .ID_VALUE(ID_VALUE)) u_mux (
    .regAddr(regAddr), .statusWord(statusWord), .ctrlWord(ctrlWord),
    .trigCount(trigCount), .wrPtr(wrPtr), .rdPtr(rdPtr), .rdFrame(rdFrame),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [6:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr,
  input logic [31:0]      statusWord,
  input logic [31:0]      trigCount
);
  localparam logic [PTR_W-1:0] LAST_SLOT = '1;

  logic wrPtrWr, rdPtrWr, cntWr, armWr;
  assign wrPtrWr = regWrEn && (regAddr == 7'd6);
  assign rdPtrWr = regWrEn && (regAddr == 7'd5);
  assign cntWr   = regWrEn && (regAddr == 7'd7);
  assign armWr   = regWrEn && (regAddr == 7'd8) && regWrData[0];

  assert_halt_when_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[2] && !wrPtrWr) |=> $stable(wrPtr));

  assert_count_no_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (trigCount <= $past(trigCount)));

  assert_full_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && !wrPtrWr && !armWr) |=> statusWord[0]);

  assert_wrap_sets_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !statusWord[3] && wrPtr == LAST_SLOT && !wrPtrWr && !armWr)
      |=> statusWord[0]);

  assert_done_needs_trig_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] |-> statusWord[1]);

  assert_read_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 7'd4 && !rdPtrWr) |=> (rdPtr == $past(rdPtr) + PTR_W'(1)));

  assert_store_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !statusWord[3] && !wrPtrWr) |=> (wrPtr == $past(wrPtr) + PTR_W'(1)));
endmodule

bind trace_ring_capture trc_checker #(.PTR_W(PTR_W)) u_check (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
  .wrPtr(wrPtr), .rdPtr(rdPtr), .statusWord(statusWord), .trigCount(trigCount)
);

// File: tb/tb_trace_ring_capture.sv
`timescale 1ns/1ps
module tb_trace_ring_capture;
  localparam int          DEPTH = 16;
  localparam logic [31:0] IDV   = 32'h7C0B_0011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [31:0] frameData = '0;
  logic        trigIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  trace_ring_capture #(.DEPTH(DEPTH), .FRAME_W(32), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .trigIn(trigIn), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fv, input logic [31:0] fd, input logic tg);
    @(negedge clk);
    frameValid = fv; frameData = fd; trigIn = tg;
    regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    frameValid = 1'b0; trigIn = 1'b0; regRdEn = 1'b0;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    frameValid = 1'b0; trigIn = 1'b0; regWrEn = 1'b0;
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  // one armed run: post-trigger count n, trigger on frame trigAt
  task automatic triggeredRun(input int n, input int trigAt, input int second, input logic [31:0] base);
    int total, stored, expWr;
    logic [31:0] expStat, v;
    regWrite(7'd6, 32'd0);
    regWrite(7'd7, n);
    regWrite(7'd8, 32'd1);
    total = trigAt + n + 5;
    for (int k = 0; k < total; k++)
      drive(1'b1, base + k, (k == trigAt) || (k == second));
    stored = trigAt + 1 + n;
    expWr = stored % DEPTH;
    expStat = 32'd14 | ((stored >= DEPTH) ? 32'd1 : 32'd0);
    expectReg("R5 stored frame count", 7'd6, expWr);
    expectReg("R3/R4/R5 status after run", 7'd3, expStat);
    expectReg("R5 counter drained", 7'd7, 32'd0);
    if (stored < DEPTH) begin
      regWrite(7'd5, 32'd0);
      for (int i = 0; i < stored; i++) begin
        regRead(7'd4, v);
        check("R6 linear readback", v, base + i);
      end
    end else begin
      regWrite(7'd5, expWr);
      for (int i = 0; i < DEPTH; i++) begin
        regRead(7'd4, v);
        check("R3/R6 oldest-first readback", v, base + (stored - DEPTH + i));
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state and constants (R1, R9)
    expectReg("R9 reset status idle", 7'd3, 32'd8);
    expectReg("R1 ident", 7'd0, IDV);
    expectReg("R1 depth", 7'd1, DEPTH);
    expectReg("R1 width", 7'd2, 32'd32);
    expectReg("R2 reset wrptr", 7'd6, 32'd0);
    for (int a = 0; a < 3; a++) regWrite(a[6:0], 32'hFFFF_FFFF);
    expectReg("R1 ident write ignored", 7'd0, IDV);
    expectReg("R1 depth write ignored", 7'd1, DEPTH);
    expectReg("R1 width write ignored", 7'd2, 32'd32);

    // R10 unmapped
    expectReg("R10 addr 9", 7'd9, 32'd0);
    expectReg("R10 addr 127", 7'd127, 32'd0);

    // R2 frames while disabled ignored
    for (int k = 0; k < 4; k++) drive(1'b1, 32'hDEAD_0000 + k, 1'b1);
    expectReg("R2 disabled frames ignored", 7'd6, 32'd0);
    expectReg("R4 trigger while disabled ignored", 7'd3, 32'd8);

    // capture without trigger, then stop (R2, R8, R4)
    regWrite(7'd7, 32'd100);
    regWrite(7'd8, 32'd1);
    expectReg("R9 capturing not idle", 7'd3, 32'd0);
    for (int k = 0; k < 5; k++) drive(1'b1, 32'h1111_0000 + k, 1'b0);
    expectReg("R2 five frames", 7'd6, 32'd5);
    regWrite(7'd8, 32'd0);
    for (int k = 0; k < 4; k++) drive(1'b1, 32'h2222_0000 + k, 1'b1);
    expectReg("R8 stop holds wrptr", 7'd6, 32'd5);
    expectReg("R8/R4 stopped status", 7'd3, 32'd8);
    expectReg("R5 count untouched without trigger", 7'd7, 32'd100);
    regWrite(7'd5, 32'd0);
    for (int i = 0; i < 5; i++) begin
      regRead(7'd4, v);
      check("R6 data read", v, 32'h1111_0000 + i);
    end
    expectReg("R6 rdptr advanced", 7'd5, 32'd5);

    // post-trigger count sweep, with and without wrap (R3, R5, R6)
    for (int n = 0; n <= 20; n++)
      triggeredRun(n, 2, -1, 32'h5000_0000 + (n << 8));

    // second trigger ignored (R4): count continues from first trigger
    triggeredRun(5, 2, 4, 32'h6600_0000);

    // full cleared by write pointer write, upper bits masked (R3, R7)
    triggeredRun(20, 1, -1, 32'h7700_0000);
    regWrite(7'd6, 32'h25);
    expectReg("R7 wrptr masked", 7'd6, 32'd5);
    expectReg("R7 wrptr write clears full", 7'd3, 32'd14);

    // re-arm clears flags, demux bit readback (R8)
    triggeredRun(18, 0, -1, 32'h8800_0000);
    regWrite(7'd8, 32'd3);
    expectReg("R8 control readback", 7'd8, 32'd3);
    expectReg("R8 arm clears flags", 7'd3, 32'd0);
    regWrite(7'd8, 32'd0);
    expectReg("R8 control cleared", 7'd8, 32'd0);

    // read pointer wrap and masking (R6, R7)
    regWrite(7'd5, 32'd15);
    regRead(7'd4, v);
    regRead(7'd4, v);
    expectReg("R6 rdptr wraps", 7'd5, 32'd1);
    regWrite(7'd5, 32'h33);
    expectReg("R7 rdptr masked", 7'd5, 32'd3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule